// File: doc/BRIEF.md
# Reconfiguration word write sequencer

This block takes configuration words, 16 bits each, from user logic and writes them one at a time to one transceiver channel, chosen by an 8-bit logical channel number. Each accepted word goes out on a serial write port, most significant bit first, while a write enable is high. Reconfiguration always targets a single channel at a time.

The block keeps the index of the next word that user logic must supply. After each word completes, it advances that index and pulses a strobe. User logic waits for the strobe, fetches the word at the new index, and then issues the next request. When the last word of the fixed-length sequence is written, the index wraps to zero and a done pulse marks the end of the channel's sequence. A clear input returns the index to zero, but only while the channel-reconfiguration mode is selected.

Top module: `cfg_word_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `word_addr`, `addr_stb`, `seq_done` and `ser_we` are all zero.
- R2: An accepted request drives `ser_we` high for exactly 16 consecutive clocks. During those clocks `ser_data` carries the captured word, bit 15 first and bit 0 last.
- R3: `busy` rises on the clock after an accepted request and stays high for 17 clocks: the 16 shift clocks plus one idle clock. It then falls.
- R4: A request made while `busy` is high is ignored. No extra word is written, and the word and channel captured earlier stay in use.
- R5: `addr_stb` is a one-cycle pulse in the cycle in which `busy` falls. In that same cycle `word_addr` shows its incremented value. At all other times `word_addr` holds, except when it is cleared.
- R6: When the word at index SEQ_LEN-1 (default 31) completes, `word_addr` wraps to 0 and `seq_done` pulses for that one cycle, together with `addr_stb`. `seq_done` is never high at any other time.
- R7: `addr_clr` high while `chan_mode` is 1 makes `word_addr` read 0 on the next clock. `addr_clr` while `chan_mode` is 0 leaves `word_addr` unchanged.
- R8: The channel number on `chan_sel` is captured on the accepted request cycle and appears on `ser_chan` throughout that word's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 8 | Logical channel number for the request |
| wr_req | input | 1 | Write request, accepted when not busy |
| wr_data | input | 16 | Configuration word to write |
| addr_clr | input | 1 | Clears the word index (channel mode only) |
| chan_mode | input | 1 | 1 = channel-reconfiguration mode |
| busy | output | 1 | A word write is in progress |
| word_addr | output | 5 | Index of the next word to supply |
| addr_stb | output | 1 | One-cycle pulse when the index advances |
| seq_done | output | 1 | One-cycle pulse after the last word |
| ser_chan | output | 8 | Channel being written |
| ser_data | output | 1 | Serial word data, MSB first |
| ser_we | output | 1 | Serial write enable |

## Verification
The bench sends a full 32-word sequence. This forces the wrap from 31 to 0, and a design with an off-by-one in its last-index compare would pulse done one word early or late, or never wrap. A second request is injected in the middle of a shift. A design that re-captures data while busy would corrupt the serial word, and one that queues the request would produce an extra strobe. The clear input is pulsed once with the mode deselected and once with it selected, which catches a clear that ignores the mode. The enable and busy lengths are also counted for every word, which exposes a missing or extra shift or idle clock.

// File: rtl/cfg_word_seq.sv
module cfg_word_seq #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int CH_W    = 8,
  parameter int SEQ_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_clr,
  input  logic              chan_mode,
  output logic              busy,
  output logic [ADDR_W-1:0] word_addr,
  output logic              addr_stb,
  output logic              seq_done,
  output logic [CH_W-1:0]   ser_chan,
  output logic              ser_data,
  output logic              ser_we
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              last_word;

  assign ser_data  = shreg[DATA_W-1];
  assign last_word = (word_addr == ADDR_W'(SEQ_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ser_we    <= 1'b0;
      word_addr <= '0;
      addr_stb  <= 1'b0;
      seq_done  <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      ser_chan  <= '0;
    end else begin
      addr_stb <= 1'b0;
      seq_done <= 1'b0;
      if (!busy) begin
        if (wr_req) begin
          busy     <= 1'b1;
          ser_we   <= 1'b1;
          shreg    <= wr_data;
          ser_chan <= chan_sel;
          cnt      <= '0;
        end
      end else if (ser_we) begin
        shreg <= shreg << 1;
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(DATA_W - 1)) ser_we <= 1'b0;
      end else begin
        busy      <= 1'b0;
        addr_stb  <= 1'b1;
        seq_done  <= last_word;
        word_addr <= last_word ? '0 : word_addr + 1'b1;
      end
      if (addr_clr && chan_mode) word_addr <= '0;
    end
  end

  a_r2_we_inside_busy: assert property (@(posedge clk) disable iff (rst)
    ser_we |-> busy);
  a_r5_stb_at_busy_fall: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> $fell(busy));
  a_r5_stb_single: assert property (@(posedge clk) disable iff (rst)
    addr_stb |=> !addr_stb);
  a_r6_done_with_wrap: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (addr_stb && word_addr == '0));
  a_r5_addr_holds: assert property (@(posedge clk) disable iff (rst)
    (!addr_stb && !$past(addr_clr && chan_mode)) |-> $stable(word_addr));
  a_r4_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && ser_we && wr_req) |=> $stable(ser_chan));
endmodule

// File: tb/tb_cfg_word_seq.sv
module tb_cfg_word_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] chan_sel = '0;
  logic wr_req = 1'b0, addr_clr = 1'b0, chan_mode = 1'b1;
  logic [15:0] wr_data = '0;
  logic busy, addr_stb, seq_done, ser_data, ser_we;
  logic [4:0] word_addr;
  logic [7:0] ser_chan;

  int checks = 0, errors = 0;
  logic [29:0] expq[$];
  logic [4:0] exp_addr = '0;
  logic [15:0] got_word;
  logic [7:0] got_chan;
  int we_run = 0, busy_run = 0, words_seen = 0, words_sent = 0;
  bit chan_bad = 0;

  always #10 clk = ~clk;

  cfg_word_seq dut (.clk(clk), .rst(rst), .chan_sel(chan_sel), .wr_req(wr_req),
    .wr_data(wr_data), .addr_clr(addr_clr), .chan_mode(chan_mode), .busy(busy),
    .word_addr(word_addr), .addr_stb(addr_stb), .seq_done(seq_done),
    .ser_chan(ser_chan), .ser_data(ser_data), .ser_we(ser_we));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic [7:0] ch, input bit poke);
    logic [4:0] nxt;
    @(negedge clk);
    while (busy) @(negedge clk);
    wr_req = 1'b1; wr_data = d; chan_sel = ch;
    nxt = (exp_addr == 5'd31) ? 5'd0 : exp_addr + 5'd1;
    expq.push_back({exp_addr == 5'd31, nxt, ch, d});
    exp_addr = nxt;
    words_sent++;
    @(negedge clk);
    wr_req = 1'b0; wr_data = ~d; chan_sel = ~ch;
    if (poke) begin
      repeat (4) @(negedge clk);
      wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_we) begin
        got_word = {got_word[14:0], ser_data};
        if (we_run == 0) got_chan = ser_chan;
        else if (ser_chan != got_chan) chan_bad = 1;
        we_run++;
      end
      if (busy) busy_run++;
      if (seq_done && !addr_stb) chk(0, "R6 done without strobe", 1, 0);
      if (addr_stb) begin
        logic [29:0] e;
        words_seen++;
        if (expq.size() == 0) chk(0, "R4 extra word written", words_seen, words_sent);
        else begin
          e = expq.pop_front();
          chk(got_word == e[15:0], "R2 serial word", got_word, e[15:0]);
          chk(got_chan == e[23:16] && !chan_bad, "R8 channel", got_chan, e[23:16]);
          chk(we_run == 16, "R2 enable length", we_run, 16);
          chk(busy_run == 17, "R3 busy length", busy_run, 17);
          chk(!busy, "R5 busy low at strobe", busy, 0);
          chk(word_addr == e[28:24], "R5 address advance", word_addr, e[28:24]);
          chk(seq_done == e[29], "R6 done pulse", seq_done, e[29]);
        end
        we_run = 0; busy_run = 0; got_word = '0; chan_bad = 0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, word_addr, addr_stb, seq_done, ser_we} == '0, "R1 reset state",
        {busy, word_addr, addr_stb, seq_done, ser_we}, 0);
    rst = 1'b0;
    send(16'h8001, 8'h12, 0);
    send(16'hA5C3, 8'hFE, 1);
    send(16'h0000, 8'h00, 0);
    @(negedge clk); while (busy) @(negedge clk);
    @(negedge clk);
    chan_mode = 1'b0; addr_clr = 1'b1;
    @(negedge clk);
    addr_clr = 1'b0;
    @(negedge clk);
    chk(word_addr == exp_addr, "R7 clear ignored outside mode", word_addr, exp_addr);
    chan_mode = 1'b1; addr_clr = 1'b1;
    @(negedge clk);
    addr_clr = 1'b0;
    chk(word_addr == 5'd0, "R7 clear in channel mode", word_addr, 0);
    exp_addr = '0;
    for (int i = 0; i < 32; i++)
      send(16'h1357 * i[15:0] ^ 16'hFFFF, 8'(i * 7), i == 9);
    @(negedge clk); while (busy || expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(words_seen == words_sent, "R4 word count", words_seen, words_sent);
    chk(word_addr == 5'd0, "R6 wrap to zero", word_addr, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule